// File: doc/BRIEF.md
# Clock-Synchronous Serial Channel

This block is one channel of a clock-synchronous serial port. Software controls it through two byte-wide registers, a control/status register and a data register. It first writes a byte into the data register, which is also the shift register. It then sets the transmit-start bit. The byte leaves on `sout`, least significant bit first. Bits shifted in from `sin` replace it one at a time. After the eighth bit, the data register holds the received byte. There is no separate receive buffer.

Reception is started by a receive-start bit, which is accepted only when the receive-enable bit is set in the same write. In master mode the channel drives its own serial clock. In slave mode it follows an external clock. Also in slave mode, starting a reception pulls an active-low ready line low, which tells the master that it may clock the byte in. Both trigger bits read back as busy flags. A one-cycle interrupt pulse marks the end of each transmit and each receive.

Top module: `ssc_channel`

## Requirements
- R1: Writing a control value with bit 0 set while the channel is idle starts a transfer. The data byte is driven on `sout` least significant bit first: a 1 bit drives high and a 0 bit drives low. In master mode each bit is stable at the rising edge of `sclk_o`.
- R2: Control bit 0 reads 1 while a transmission runs and 0 otherwise, and it is 0 after reset. A control write with bit 0 clear starts nothing.
- R3: A control write with both bit 2 and bit 1 set, made while idle, starts a reception. Control bit 2 reads 1 while receiving. The eight `sin` levels sampled at the rising serial-clock edges fill the data register least significant bit first, with high read as 1.
- R4: Control bit 1 (receive enable) resets to 0. A write with bit 2 set but bit 1 clear starts no reception. Clearing bit 1 during a reception stops it, with no completion interrupt and no further shifting.
- R5: When a reception starts with control bit 3 (slave mode) set, `rdy_n` is low in the cycle after the write. It stays low until the eighth bit is taken or the reception stops. In master mode `rdy_n` stays high.
- R6: In master mode `sclk_o` idles high. During a transfer it produces exactly eight low pulses, with a rising edge every 2*HALF_DIV clock cycles.
- R7: In slave mode the channel shifts on the edges of `sclk_i` and leaves `sclk_o` high.
- R8: When the eighth bit is taken, the busy flags clear. `tx_irq` and/or `rx_irq` then pulse high for exactly one cycle, one pulse for each direction that was busy.
- R9: A data register write is accepted only while idle. Writes during a transfer are ignored. Reading the data register returns the shift register contents.
- R10: `rd_data` is registered: it shows the register selected by `rd_sel` (0 control, 1 data) one clock after selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | DATA_W | Write value |
| rd_sel | input | 1 | Read source: 0 control, 1 data |
| rd_data | output | DATA_W | Registered read value |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | External serial clock used in slave mode |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |
| rdy_n | output | 1 | Active-low slave ready |
| tx_irq | output | 1 | Transmit-complete pulse |
| rx_irq | output | 1 | Receive-complete pulse |

## Verification
The assertions assume three things about the inputs:
- The external serial clock idles high and each of its phases lasts several system clocks longer than the synchronizer depth.
- `sin` changes only while the serial clock is low.
- The mode bit is changed only while the channel is idle.

The bench models the far end to match. As a master it changes `sin` on the falling edge of `sclk_o`. As a slave-mode clock source it holds each `sclk_i` phase for eight cycles and sets `sin` together with the falling edge. It writes configuration only between transfers.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int BIT_TX   = 0;
  localparam int BIT_RXEN = 1;
  localparam int BIT_RX   = 2;
  localparam int BIT_SLV  = 3;
  typedef enum logic {SEL_CTRL = 1'b0, SEL_DATA = 1'b1} reg_sel_e;
endpackage

// File: rtl/ssc_clk_eng.sv
module ssc_clk_eng #(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slave,
  input  logic run,
  input  logic sclk_in,
  output logic sclk_out,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] div_q;
  logic m_clk_q, m_rise_q, m_fall_q;
  logic [SYNC_STAGES:0] sck_sync;
  logic s_rise, s_fall;

  // master clock generator
  always_ff @(posedge clk) begin
    if (rst || !run || slave) begin
      div_q    <= '0;
      m_clk_q  <= 1'b1;
      m_rise_q <= 1'b0;
      m_fall_q <= 1'b0;
    end else begin
      m_rise_q <= 1'b0;
      m_fall_q <= 1'b0;
      if (div_q == CW'(HALF_DIV - 1)) begin
        div_q    <= '0;
        m_clk_q  <= ~m_clk_q;
        m_rise_q <= ~m_clk_q;
        m_fall_q <= m_clk_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // slave clock synchronizer and edge detect
  always_ff @(posedge clk) begin
    if (rst) sck_sync <= '1;
    else     sck_sync <= {sck_sync[SYNC_STAGES-1:0], sclk_in};
  end

  assign s_rise   = sck_sync[SYNC_STAGES-1] & ~sck_sync[SYNC_STAGES];
  assign s_fall   = ~sck_sync[SYNC_STAGES-1] & sck_sync[SYNC_STAGES];
  assign sclk_out = m_clk_q;
  assign rise     = slave ? (s_rise & run) : m_rise_q;
  assign fall     = slave ? (s_fall & run) : m_fall_q;

  p_idle_high_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> sclk_out);
  p_slave_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    slave |=> sclk_out);
endmodule

// File: rtl/ssc_shift_core.sv
module ssc_shift_core #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              active,
  input  logic              rise,
  input  logic              fall,
  input  logic              sin,
  output logic [DATA_W-1:0] shreg,
  output logic              sout,
  output logic              last
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [CNT_W-1:0] bit_q;
  logic             sout_q;
  logic             sin_s;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic sin_q;
      always_ff @(posedge clk) begin
        if (rst) sin_q <= 1'b0;
        else     sin_q <= sin;
      end
      assign sin_s = sin_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sin_q;
      always_ff @(posedge clk) begin
        if (rst) sin_q <= '0;
        else     sin_q <= {sin_q[SYNC_STAGES-2:0], sin};
      end
      assign sin_s = sin_q[SYNC_STAGES-1];
    end
  endgenerate

  assign last = active & rise & (bit_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      bit_q  <= '0;
      sout_q <= 1'b0;
    end else if (!active) begin
      bit_q  <= '0;
      sout_q <= shreg[0];
      if (load) shreg <= load_val;
    end else begin
      if (rise) begin
        shreg <= {sin_s, shreg[DATA_W-1:1]};
        bit_q <= bit_q + 1'b1;
      end
      if (fall) sout_q <= shreg[0];
    end
  end

  assign sout = sout_q;

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!active && !load) |=> $stable(shreg));
endmodule

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
  import ssc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  input  logic              last,
  input  logic [DATA_W-1:0] shreg,
  output logic              load,
  output logic              active,
  output logic              slave,
  output logic              rdy_n,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic [DATA_W-1:0] rd_data
);
  logic tx_busy, rx_busy, rx_en;
  logic ctrl_wr, tx_start, rx_start, rx_stop;
  logic [DATA_W-1:0] ctrl_view;

  assign active   = tx_busy | rx_busy;
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign load     = wr_en && (wr_sel == SEL_DATA) && !active;
  assign tx_start = ctrl_wr && wr_data[BIT_TX] && !active;
  assign rx_start = ctrl_wr && wr_data[BIT_RX] && wr_data[BIT_RXEN] && !active;
  assign rx_stop  = ctrl_wr && !wr_data[BIT_RXEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy <= 1'b0;
      rx_busy <= 1'b0;
      rx_en   <= 1'b0;
      slave   <= 1'b0;
      rdy_n   <= 1'b1;
      tx_irq  <= 1'b0;
      rx_irq  <= 1'b0;
    end else begin
      tx_irq <= last & tx_busy;
      rx_irq <= last & rx_busy & !rx_stop;
      if (ctrl_wr) rx_en <= wr_data[BIT_RXEN];
      if (ctrl_wr && !active) slave <= wr_data[BIT_SLV];
      if (tx_start)  tx_busy <= 1'b1;
      else if (last) tx_busy <= 1'b0;
      if (rx_start) begin
        rx_busy <= 1'b1;
        rdy_n   <= !wr_data[BIT_SLV];
      end else if (last || rx_stop) begin
        rx_busy <= 1'b0;
        rdy_n   <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[BIT_TX]   = tx_busy;
    ctrl_view[BIT_RXEN] = rx_en;
    ctrl_view[BIT_RX]   = rx_busy;
    ctrl_view[BIT_SLV]  = slave;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= (rd_sel == SEL_DATA) ? shreg : ctrl_view;
  end

  p_txirq_r8: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (!tx_busy && $past(tx_busy)));
  p_rxirq_r8: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> (!rx_busy && $past(rx_busy)));
  p_rx_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    rx_busy |-> rx_en);
  p_ready_slave_r5: assert property (@(posedge clk) disable iff (rst)
    !rdy_n |-> (slave && rx_busy));
endmodule

// File: rtl/ssc_channel.sv
module ssc_channel #(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              sclk_o,
  input  logic              sclk_i,
  output logic              sout,
  input  logic              sin,
  output logic              rdy_n,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic              load, active, slave, rise, fall, last;
  logic [DATA_W-1:0] shreg;

  ssc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .last(last), .shreg(shreg), .load(load), .active(active),
    .slave(slave), .rdy_n(rdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .rd_data(rd_data)
  );

  ssc_clk_eng #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst(rst), .slave(slave), .run(active), .sclk_in(sclk_i),
    .sclk_out(sclk_o), .rise(rise), .fall(fall)
  );

  ssc_shift_core #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data), .active(active),
    .rise(rise), .fall(fall), .sin(sin), .shreg(shreg), .sout(sout),
    .last(last)
  );
endmodule

// File: tb/ssc_channel_bench.sv
`timescale 1ns/1ps
module ssc_channel_bench;
  localparam int DW = 8;
  localparam int HD = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic sclk_o, sclk_i = 1'b1, sout, sin = 1'b0, rdy_n, tx_irq, rx_irq;

  ssc_channel #(.DATA_W(DW), .HALF_DIV(HD), .SYNC_STAGES(2)) u_ssc_channel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sclk_o(sclk_o), .sclk_i(sclk_i),
    .sout(sout), .sin(sin), .rdy_n(rdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, tx_cnt = 0, rx_cnt = 0, wide = 0, rdy_low = 0;
  int m_rises = 0, m_idx = 0, last_rise = 0, per_bad = 0;
  logic tx_prev = 1'b0, rx_prev = 1'b0;
  logic [DW-1:0] rx_pat = '0, cap_m = '0;
  logic [DW-1:0] exp_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sb_compare(input logic [DW-1:0] got, input string req);
    logic [DW-1:0] e;
    if (exp_q.size() == 0) begin
      check({req, " (no expected item)"}, 32'(got), 32'hFFFF_FFFF);
    end else begin
      e = exp_q.pop_front();
      check(req, 32'(got), 32'(e));
    end
  endtask

  // irq pulse, ready and cycle monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (tx_irq) tx_cnt++;
      if (rx_irq) rx_cnt++;
      if ((tx_irq && tx_prev) || (rx_irq && rx_prev)) wide++;
      if (!rdy_n) rdy_low++;
    end
    tx_prev = tx_irq;
    rx_prev = rx_irq;
  end

  // master-mode far end: captures sout at rising sclk_o, drives sin at falling
  always @(posedge sclk_o) begin
    cap_m[m_idx] = sout;
    if (m_idx > 0 && (cyc - last_rise) != 2 * HD) per_bad++;
    last_rise = cyc;
    m_rises++;
    m_idx++;
    if (m_idx == DW) begin
      sb_compare(cap_m, "R1 master serial byte");
      m_idx = 0;
    end
  end
  always @(negedge sclk_o) begin
    if (m_idx < DW) sin = rx_pat[m_idx];
  end

  task automatic wr(input logic sel, input logic [DW-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [DW-1:0] v);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_tx(input int start);
    for (int i = 0; i < 2000 && tx_cnt == start; i++) @(negedge clk);
  endtask
  task automatic wait_rx(input int start);
    for (int i = 0; i < 2000 && rx_cnt == start; i++) @(negedge clk);
  endtask

  // slave-mode far end acting as clock master
  task automatic drive_slave(input logic [DW-1:0] pat, input int nbits, output logic [DW-1:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sclk_i = 1'b0; sin = pat[i];
      repeat (8) @(negedge clk);
      got[i] = sout;
      sclk_i = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v, got;
    int t0, r0, m0, l0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(1'b0, v);
    check("R2/R4 control after reset", 32'(v), 32'h00);
    check("R5 rdy_n after reset", 32'(rdy_n), 32'h1);
    check("R6 sclk_o idle high", 32'(sclk_o), 32'h1);

    // master full duplex
    wr(1'b1, 8'hA5);
    rx_pat = 8'h3C; sin = rx_pat[0]; m_idx = 0;
    exp_q.push_back(8'hA5);
    t0 = tx_cnt; r0 = rx_cnt; m0 = m_rises; l0 = rdy_low;
    wr(1'b0, 8'h07);
    rd(1'b0, v);
    check("R2/R3 busy flags during transfer", 32'(v), 32'h07);
    wr(1'b1, 8'hFF);
    wait_tx(t0);
    repeat (4) @(negedge clk);
    check("R8 tx_irq one pulse", 32'(tx_cnt - t0), 32'd1);
    check("R8 rx_irq one pulse", 32'(rx_cnt - r0), 32'd1);
    check("R6 eight sclk_o rises", 32'(m_rises - m0), 32'd8);
    check("R6 sclk_o period", 32'(per_bad), 32'd0);
    check("R5 rdy_n high in master", 32'(rdy_low - l0), 32'd0);
    rd(1'b0, v);
    check("R8 busy cleared after byte", 32'(v), 32'h02);
    rd(1'b1, v);
    check("R3/R9 received byte, busy write ignored", 32'(v), 32'h3C);

    // write 0 to tx bit: nothing starts
    m0 = m_rises;
    wr(1'b0, 8'h02);
    repeat (40) @(negedge clk);
    check("R2 write 0 starts nothing", 32'(m_rises - m0), 32'd0);
    rd(1'b0, v);
    check("R2 tx busy stays 0", 32'(v), 32'h02);

    // rx trigger without enable
    wr(1'b1, 8'h11);
    rd(1'b1, v);
    check("R9 idle data write loads", 32'(v), 32'h11);
    m0 = m_rises; r0 = rx_cnt;
    wr(1'b0, 8'h04);
    repeat (40) @(negedge clk);
    rd(1'b0, v);
    check("R4 rx trigger ignored without enable", 32'(v), 32'h00);
    check("R4 no clock without enable", 32'(m_rises - m0), 32'd0);
    check("R4 no rx irq without enable", 32'(rx_cnt - r0), 32'd0);

    // master transmit only
    wr(1'b1, 8'h96);
    rx_pat = 8'h00; sin = 1'b0; m_idx = 0;
    exp_q.push_back(8'h96);
    t0 = tx_cnt; r0 = rx_cnt;
    wr(1'b0, 8'h01);
    wait_tx(t0);
    repeat (4) @(negedge clk);
    check("R8 tx-only tx_irq", 32'(tx_cnt - t0), 32'd1);
    check("R8 tx-only no rx_irq", 32'(rx_cnt - r0), 32'd0);
    check("R8 irq pulses one cycle wide", 32'(wide), 32'd0);
    rd(1'b0, v);
    check("R2 idle after tx-only", 32'(v), 32'h00);

    // slave receive
    wr(1'b0, 8'h08);
    m0 = m_rises; r0 = rx_cnt;
    wr(1'b0, 8'h0E);
    check("R5 rdy_n low after rx trigger", 32'(rdy_n), 32'h0);
    drive_slave(8'hC3, 4, got);
    check("R5 rdy_n low mid byte", 32'(rdy_n), 32'h0);
    drive_slave(8'h0C, 4, got);
    repeat (6) @(negedge clk);
    check("R5 rdy_n high after eighth bit", 32'(rdy_n), 32'h1);
    check("R8 slave rx_irq", 32'(rx_cnt - r0), 32'd1);
    check("R7 sclk_o quiet in slave", 32'(m_rises - m0), 32'd0);
    rd(1'b1, v);
    check("R3/R7 slave received byte", 32'(v), 32'hC3);
    rd(1'b0, v);
    check("R8 slave rx idle", 32'(v), 32'h0A);

    // slave transmit
    wr(1'b1, 8'h5A);
    exp_q.push_back(8'h5A);
    t0 = tx_cnt;
    wr(1'b0, 8'h09);
    drive_slave(8'h00, 8, got);
    sb_compare(got, "R1/R7 slave serial byte");
    repeat (6) @(negedge clk);
    check("R8 slave tx_irq", 32'(tx_cnt - t0), 32'd1);
    check("R5 rdy_n high for tx-only", 32'(rdy_n), 32'h1);

    // receive abort by clearing enable
    r0 = rx_cnt;
    wr(1'b0, 8'h0E);
    drive_slave(8'hFF, 3, got);
    wr(1'b0, 8'h08);
    check("R4 rdy_n released on abort", 32'(rdy_n), 32'h1);
    rd(1'b1, v);
    got = v;
    drive_slave(8'hFF, 5, v);
    repeat (6) @(negedge clk);
    check("R4 no rx_irq after abort", 32'(rx_cnt - r0), 32'd0);
    rd(1'b0, v);
    check("R4 control after abort", 32'(v), 32'h08);
    rd(1'b1, v);
    check("R4 no shifting after abort", 32'(v), 32'(got));
    check("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);

    finish_run();
  end
endmodule